// File: doc/BRIEF.md
# XGMII Transmit Framer with Deficit Idle Count

This block sits on the transmit path of a 10 Gb/s Ethernet MAC. It sits between the client byte stream and a 32-bit, four-lane XGMII. Client frames arrive as 32-bit words with a valid/ready handshake. Each word carries a first-word marker, a last-word marker and a count of the valid bytes in the last word. The framer opens every frame with a start control character in lane 0, followed by preamble bytes and the start-of-frame delimiter. It then passes the client bytes through in lane order, closes the frame with a terminate control character, and fills the gap with idle control characters.

The inter-packet gap is set by a deficit idle count. A frame that ends part-way through a column leaves a fractional column. The framer resolves this by shortening or stretching the gap so that the next start character falls on lane 0. A small deficit counter records how many idle bytes have been removed so far. This keeps every gap between 9 and 15 bytes and the long-run average at exactly 12 bytes. The client is held off (ready low) whenever the framer emits a column that carries no client data.

Top module: `xgmii_tx_framer`

## Requirements
- R1: After reset, and while no frame is offered, every output column is idle: all four lanes carry 0x07 with all four control bits set (txCtrl = 4'hF).
- R2: A frame opens with two columns. The first carries start 0xFB in lane 0 (control bit set) and 0x55 in lanes 1 to 3. The second carries 0x55 in lanes 0 to 2 and SFD 0xD5 in lane 3, with all control bits clear.
- R3: Client bits [8i+7:8i] leave on lane i (txData bits [8i+7:8i]) with control bit i clear. The first client word appears in the column right after the SFD column, and data bytes beyond the last valid one are never sent.
- R4: The terminate character 0xFD (control bit set) follows the last valid byte at once. inBytes gives the valid-byte count of the last word, with 0 meaning four. For 1 to 3 valid bytes, 0xFD goes in lane inBytes of the same column. For four, 0xFD goes in lane 0 of the next column.
- R5: Every gap byte after the terminate character is 0x07 with its control bit set. The column after any column holding a terminate character is fully idle.
- R6: A start character only ever appears in lane 0.
- R7: With frames offered back to back, the gap is counted from the byte after the last data byte up to the start character, terminate included. The gap is 12 when the frame ends on a full word. Otherwise let s be the valid-byte count of the last word. If deficit + s <= 3, the gap is 12 - s; if not, the gap is 16 - s.
- R8: The deficit starts at 0 after reset. It becomes (deficit + s) mod 4 after each frame, so a full last word leaves it unchanged. Over any back-to-back run that brings it back to 0, the mean gap is exactly 12 bytes.
- R9: inReady is low in reset, in idle, preamble, terminate-only and gap columns, and high only while client words are being placed. A frame offered to an idle framer is taken two cycles after it is first offered. inReady stays high for every word of a frame after the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inData | input | 32 | Client word, byte 0 in bits [7:0] |
| inValid | input | 1 | Client word valid |
| inStart | input | 1 | Word is the first of a frame |
| inEnd | input | 1 | Word is the last of a frame |
| inBytes | input | 2 | Valid bytes in the last word, 0 encodes four |
| inReady | output | 1 | Framer accepts the word this cycle |
| txData | output | 32 | XGMII data, lane i in bits [8i+7:8i] |
| txCtrl | output | 4 | XGMII control bit per lane |

## Verification
The assertions take for granted that a client never lets inValid drop between the first and last word of a frame. This is an underrun the XGMII cannot express, and one assertion flags it. They also assume that a frame offered to an idle framer is marked with inStart. The stimulus holds valid high from the first word of the first frame through the last word of the last frame. Each next frame is offered in the same cycle its predecessor's last word is taken, so every gap is the minimum the deficit rule allows and can be compared byte for byte against the expected value.

// File: rtl/xgtx_pkg.sv
package xgtx_pkg;

  // Lane geometry of the XGMII column
  localparam int LANES  = 4;
  localparam int LANE_W = $clog2(LANES);
  localparam int DATA_W = 8 * LANES;

  // Characters placed on the XGMII
  localparam logic [7:0] CH_IDLE  = 8'h07;
  localparam logic [7:0] CH_START = 8'hFB;
  localparam logic [7:0] CH_TERM  = 8'hFD;
  localparam logic [7:0] CH_PRE   = 8'h55;
  localparam logic [7:0] CH_SFD   = 8'hD5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_DATA,
    ST_TERM,
    ST_GAP
  } txState_t;

  // Strobes from control to datapath: exactly one send* is set each cycle
  typedef struct packed {
    logic              sendIdle;
    logic              sendHead;
    logic              sendSfd;
    logic              sendData;
    logic              sendTerm;
    logic              endHere;
    logic [LANE_W-1:0] endBytes;
  } colStrobe_t;

endpackage

// File: rtl/xgtx_ctrl.sv
module xgtx_ctrl
  import xgtx_pkg::*;
#(
  parameter int IPG_BYTES = 12  // multiple of LANES, at least 2*LANES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic              inStart,
  input  logic              inEnd,
  input  logic [LANE_W-1:0] inBytes,
  output logic              inReady,
  output colStrobe_t        strobe
);

  localparam int GAP_COLS_DOWN = IPG_BYTES / LANES - 1;
  localparam int GAP_COLS_UP   = IPG_BYTES / LANES;
  localparam int CNT_W         = $clog2(GAP_COLS_UP + 1);
  localparam int DEF_MAX       = LANES - 1;

  txState_t          state;
  logic [LANE_W-1:0] deficit;
  logic [CNT_W-1:0]  gapLeft;
  logic [LANE_W:0]   defSum;
  logic              shorten;
  logic              accept;

  assign inReady = (state == ST_DATA);
  assign accept  = inValid && inReady;
  // Bytes the gap falls short of IPG when rounded down to a full column,
  // added to the running deficit
  assign defSum  = {1'b0, deficit} + {1'b0, inBytes};
  assign shorten = (defSum <= (LANE_W+1)'(DEF_MAX));

  always_comb begin
    strobe          = '0;
    strobe.endBytes = inBytes;
    unique case (state)
      ST_IDLE: begin
        if (inValid && inStart) strobe.sendHead = 1'b1;
        else                    strobe.sendIdle = 1'b1;
      end
      ST_PRE:  strobe.sendSfd = 1'b1;
      ST_DATA: begin
        if (inValid) begin
          strobe.sendData = 1'b1;
          strobe.endHere  = inEnd;
        end else begin
          strobe.sendIdle = 1'b1;
        end
      end
      ST_TERM: strobe.sendTerm = 1'b1;
      default: strobe.sendIdle = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      deficit <= '0;
      gapLeft <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (inValid && inStart) state <= ST_PRE;
        ST_PRE:  state <= ST_DATA;
        ST_DATA: begin
          if (accept && inEnd) begin
            // Both outcomes leave (deficit + s) mod LANES
            deficit <= defSum[LANE_W-1:0];
            if (inBytes == '0) begin
              state <= ST_TERM;
            end else begin
              state   <= ST_GAP;
              gapLeft <= shorten ? CNT_W'(GAP_COLS_DOWN) : CNT_W'(GAP_COLS_UP);
            end
          end
        end
        ST_TERM: begin
          state   <= ST_GAP;
          gapLeft <= CNT_W'(GAP_COLS_DOWN);
        end
        default: begin
          gapLeft <= gapLeft - 1'b1;
          if (gapLeft == CNT_W'(1)) state <= ST_IDLE;
        end
      endcase
    end
  end

  // R3: a frame in progress must not be starved by the client
  no_underrun_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DATA) |-> inValid);

  // R8
  full_end_deficit_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && inEnd && inBytes == '0) |=> $stable(deficit));

  // R9
  gap_no_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && inEnd) |=> !inReady);

endmodule

// File: rtl/xgtx_datapath.sv
module xgtx_datapath
  import xgtx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  colStrobe_t        strobe,
  input  logic [DATA_W-1:0] inData,
  output logic [DATA_W-1:0] txData,
  output logic [LANES-1:0]  txCtrl
);

  logic [7:0]       nxtByte [LANES];
  logic             nxtCtl  [LANES];
  logic [LANES-1:0] termSeen;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_comb begin
      nxtByte[l] = CH_IDLE;
      nxtCtl[l]  = 1'b1;
      if (strobe.sendHead) begin
        nxtByte[l] = (l == 0) ? CH_START : CH_PRE;
        nxtCtl[l]  = (l == 0);
      end else if (strobe.sendSfd) begin
        nxtByte[l] = (l == LANES - 1) ? CH_SFD : CH_PRE;
        nxtCtl[l]  = 1'b0;
      end else if (strobe.sendTerm) begin
        nxtByte[l] = (l == 0) ? CH_TERM : CH_IDLE;
        nxtCtl[l]  = 1'b1;
      end else if (strobe.sendData) begin
        if (!strobe.endHere || strobe.endBytes == '0 ||
            LANE_W'(l) < strobe.endBytes) begin
          nxtByte[l] = inData[l*8 +: 8];
          nxtCtl[l]  = 1'b0;
        end else if (LANE_W'(l) == strobe.endBytes) begin
          nxtByte[l] = CH_TERM;
          nxtCtl[l]  = 1'b1;
        end
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        txData[l*8 +: 8] <= CH_IDLE;
        txCtrl[l]        <= 1'b1;
      end else begin
        txData[l*8 +: 8] <= nxtByte[l];
        txCtrl[l]        <= nxtCtl[l];
      end
    end

    assign termSeen[l] = txCtrl[l] && (txData[l*8 +: 8] == CH_TERM);

    if (l > 0) begin : g_startChk
      // R6
      start_lane_chk: assert property (@(posedge clk) disable iff (rst)
        !(txCtrl[l] && txData[l*8 +: 8] == CH_START));
    end
  end

  // R2
  sfd_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (txCtrl[0] && txData[7:0] == CH_START) |=>
      (txCtrl == '0 && txData[DATA_W-1 -: 8] == CH_SFD));

  // R5
  idle_after_term_chk: assert property (@(posedge clk) disable iff (rst)
    (|termSeen) |=> (txCtrl == '1 && txData == {LANES{CH_IDLE}}));

endmodule

// File: rtl/xgmii_tx_framer.sv
module xgmii_tx_framer
  import xgtx_pkg::*;
#(
  parameter int IPG_BYTES = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] inData,
  input  logic              inValid,
  input  logic              inStart,
  input  logic              inEnd,
  input  logic [LANE_W-1:0] inBytes,
  output logic              inReady,
  output logic [DATA_W-1:0] txData,
  output logic [LANES-1:0]  txCtrl
);

  colStrobe_t strobe;

  xgtx_ctrl #(.IPG_BYTES(IPG_BYTES)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .inStart (inStart),
    .inEnd   (inEnd),
    .inBytes (inBytes),
    .inReady (inReady),
    .strobe  (strobe)
  );

  xgtx_datapath u_dp (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe),
    .inData (inData),
    .txData (txData),
    .txCtrl (txCtrl)
  );

endmodule

// File: tb/xgmii_tx_framer_test.sv
`timescale 1ns/1ps
module xgmii_tx_framer_test;

  localparam int FRAME_CNT = 12;
  localparam int CAP_MAX   = 4096;
  // Stimulus: frame lengths in bytes; expected: gap after each frame (R7)
  localparam int lenTab [FRAME_CNT] = '{5, 6, 7, 8, 9, 9, 3, 2, 4, 14, 1, 16};
  localparam int gapTab [FRAME_CNT] = '{11, 10, 13, 12, 11, 15, 9, 14, 12, 10, 15, 0};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] inData = '0;
  logic        inValid = 1'b0;
  logic        inStart = 1'b0;
  logic        inEnd = 1'b0;
  logic [1:0]  inBytes = '0;
  logic        inReady;
  logic [31:0] txData;
  logic [3:0]  txCtrl;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit capOn  = 1'b0;
  logic [8:0] cap [CAP_MAX];
  int capN = 0;

  always #10 clk = ~clk;

  xgmii_tx_framer uut (
    .clk(clk), .rst(rst), .inData(inData), .inValid(inValid),
    .inStart(inStart), .inEnd(inEnd), .inBytes(inBytes),
    .inReady(inReady), .txData(txData), .txCtrl(txCtrl)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pay(input int f, input int i);
    return 8'(f * 37 + i * 5 + 1);
  endfunction

  // Capture every lane of every column, lane 0 first
  always @(negedge clk) begin
    if (capOn) begin
      for (int l = 0; l < 4; l++) begin
        if (capN < CAP_MAX) begin
          cap[capN] = {txCtrl[l], txData[l*8 +: 8]};
          capN++;
        end
      end
    end
  end

  task automatic sendFrame(input int f);
    int len, words, waits, midBad, expWait, nPrev;
    len    = lenTab[f];
    words  = (len + 3) / 4;
    midBad = 0;
    expWait = 2;
    if (f > 0) begin
      nPrev   = ((lenTab[f-1] - 1) % 4) + 1;
      expWait = (gapTab[f-1] - (4 - nPrev)) / 4 + 2;
    end
    for (int w = 0; w < words; w++) begin
      for (int b = 0; b < 4; b++) begin
        inData[b*8 +: 8] = (w*4 + b < len) ? pay(f, w*4 + b) : 8'hEE;
      end
      inValid = 1'b1;
      inStart = (w == 0);
      inEnd   = (w == words - 1);
      inBytes = 2'(len % 4);
      waits = 0;
      while (!inReady) begin
        @(negedge clk);
        waits++;
      end
      if (w == 0) check(waits == expWait, "R9 first-word wait", waits, expWait);
      else if (waits != 0) midBad++;
      @(negedge clk);
    end
    check(midBad == 0, "R9 ready held within frame", midBad, 0);
  endtask

  initial begin
    int p, ok, bad, cnt, gap, gapSum, len;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 / R9: reset state
    check(txCtrl == 4'hF, "R1 reset ctrl", txCtrl, 15);
    check(txData == 32'h07070707, "R1 reset data", txData, 32'h07070707);
    check(inReady == 1'b0, "R9 reset ready", inReady, 0);
    repeat (4) @(negedge clk);
    check(txCtrl == 4'hF && txData == 32'h07070707, "R1 idle with no frame", txData, 32'h07070707);
    check(inReady == 1'b0, "R9 idle ready", inReady, 0);

    capOn = 1'b1;
    for (int f = 0; f < FRAME_CNT; f++) sendFrame(f);
    inValid = 1'b0;
    inStart = 1'b0;
    inEnd   = 1'b0;
    repeat (8) @(negedge clk);
    capOn = 1'b0;

    // Walk the captured byte stream
    p = 0;
    bad = 0;
    while (p < capN && cap[p] != {1'b1, 8'hFB}) begin
      if (cap[p] != {1'b1, 8'h07}) bad++;
      p++;
    end
    check(bad == 0, "R1 idle before first frame", bad, 0);
    gapSum = 0;
    for (int f = 0; f < FRAME_CNT; f++) begin
      len = lenTab[f];
      check(p < capN && cap[p] == {1'b1, 8'hFB} && p % 4 == 0, "R6 start in lane 0", p % 4, 0);
      ok = 1;
      for (int i = 1; i < 7; i++) if (cap[p+i] != {1'b0, 8'h55}) ok = 0;
      if (cap[p+7] != {1'b0, 8'hD5}) ok = 0;
      check(ok == 1, "R2 preamble and SFD", ok, 1);
      p += 8;
      bad = -1;
      for (int i = 0; i < len; i++) begin
        if (bad < 0 && cap[p+i] != {1'b0, pay(f, i)}) bad = i;
      end
      check(bad < 0, "R3 data lane order", bad, -1);
      p += len;
      check(cap[p] == {1'b1, 8'hFD}, "R4 terminate position", cap[p], 9'h1FD);
      p++;
      cnt = 0;
      bad = 0;
      while (p < capN && cap[p] != {1'b1, 8'hFB}) begin
        if (cap[p] != {1'b1, 8'h07}) bad++;
        cnt++;
        p++;
      end
      check(bad == 0, "R5 idle fill", bad, 0);
      gap = cnt + 1;
      if (f < FRAME_CNT - 1) begin
        check(gap == gapTab[f], "R7 deficit idle gap", gap, gapTab[f]);
        check(gap >= 9 && gap <= 15, "R7 gap bounds", gap, 12);
        gapSum += gap;
      end
    end
    // R8: the table returns the deficit to 0, so the mean must be 12
    check(gapSum == 12 * (FRAME_CNT - 1), "R8 mean gap", gapSum, 12 * (FRAME_CNT - 1));

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule